// File: doc/BRIEF.md
# Peripheral Security Attribute Register Bank

This block holds the security attribute of each peripheral in a memory-mapped bank of two 32-bit registers. The secure-mode register marks each peripheral as secure (1) or non-secure (0). The privilege-attribute register decides, bit by bit, whether a secure write to the matching secure-mode bit must also be privileged. Both registers are driven continuously on output ports, so access filters elsewhere in the chip always see the current attribute vectors.

Software reaches the bank through a single-cycle request/response port. Each request carries a write flag, an address, write data, byte strobes, a secure flag and a privileged flag. One cycle later the bank returns a response with read data and an error flag. Reads are open to every requester. Writes are decided per bit. A non-secure writer changes nothing. A secure writer without privilege changes only the bits whose privilege-attribute bit is clear. A secure privileged writer may change every implemented bit.

Top module: `periph_sec_attr_bank`

## Requirements
- R1: After reset both registers read 0x0000_0000, both vector outputs are 0 and `rspValid` is 0.
- R2: A secure, privileged, word write to the secure-mode register (offset 0x018) loads every implemented bit from the write data and responds without error.
- R3: A secure, non-privileged, word write to offset 0x018 updates only the implemented bits whose privilege-attribute bit is 0. Bits whose privilege-attribute bit is 1 keep their value. The response carries no error.
- R4: A non-secure write to either register changes neither register and responds with `rspErr` = 1.
- R5: Implemented bits are 31..26 and 24 (mask 0xFD00_0000) in both registers. Bit 25 and bits 23..0 always read 0 and ignore writes.
- R6: A word read of offset 0x018 or offset 0x028 returns the register contents with `rspErr` = 0, whatever the secure and privileged flags are.
- R7: An access is a word access only when `reqStrb` is 4'hF and `reqAddr[1:0]` is 0. Any other access responds with `rspErr` = 1 and `rspRdata` = 0, and changes no state.
- R8: The privilege-attribute register (offset 0x028) is written only by secure, privileged word writes. A secure, non-privileged write to it responds with `rspErr` = 1 and leaves it unchanged.
- R9: An access to any offset other than 0x018 or 0x028 responds with `rspErr` = 1 and `rspRdata` = 0.
- R10: Every request is answered by exactly one response, with `rspValid` high in the cycle after the request. `rspValid` is low in every other cycle. Write responses carry `rspRdata` = 0.
- R11: The vector outputs show the new register values in the cycle after an accepted write, and they do not change in any cycle that follows no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (12) | Byte offset within the bank |
| reqWdata | input | DATA_W (32) | Write data |
| reqStrb | input | DATA_W/8 (4) | Byte strobes |
| reqSecure | input | 1 | Request comes from the secure world |
| reqPriv | input | 1 | Request comes from privileged code |
| rspValid | output | 1 | Response present this cycle |
| rspErr | output | 1 | Request was rejected |
| rspRdata | output | DATA_W (32) | Read data |
| secModeVec | output | DATA_W (32) | Current secure-mode register |
| privAttrVec | output | DATA_W (32) | Current privilege-attribute register |

## Verification
The assertions check some rules in every cycle. Non-secure writes leave both vectors unchanged and return an error. A non-privileged secure write never flips a bit whose privilege attribute is set. Reserved bits stay zero. Error responses carry zero data. Each request gets exactly one response in the following cycle. Other behaviour shows only in the bench's scenarios, which compare against a bench model: which bits a permitted write actually changes, that reads ignore the requester's flags, and how misaligned, partial-strobe and unmapped accesses are classified.

// File: rtl/psab_pkg.sv
package psab_pkg;

  // Strobes that the access-control decoder hands to the register datapath.
  typedef struct packed {
    logic acc;      // a request is present this cycle
    logic wrSec;    // accepted write to the secure-mode register
    logic wrPriv;   // accepted write to the privilege-attribute register
    logic rdSec;    // accepted read of the secure-mode register
    logic rdPriv;   // accepted read of the privilege-attribute register
    logic useMask;  // writer lacks privilege: protected bits are locked
    logic err;      // request rejected
  } ctrlStrobes_t;

endpackage

// File: rtl/psab_ctrl.sv
module psab_ctrl
  import psab_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] SEC_OFF  = 12'h018,
  parameter logic [ADDR_W-1:0] PRIV_OFF = 12'h028
) (
  input  logic                  reqValid,
  input  logic                  reqWrite,
  input  logic [ADDR_W-1:0]     reqAddr,
  input  logic [DATA_W/8-1:0]   reqStrb,
  input  logic                  reqSecure,
  input  logic                  reqPriv,
  output ctrlStrobes_t          strobes
);

  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned LSB_W  = $clog2(STRB_W);

  logic wordOk;
  logic hitSec;
  logic hitPriv;
  logic isWr;
  logic isRd;

  always_comb begin
    // Full-word access only: every strobe lit and the address word aligned.
    wordOk  = (&reqStrb) && (reqAddr[LSB_W-1:0] == '0);
    hitSec  = wordOk && (reqAddr == SEC_OFF);
    hitPriv = wordOk && (reqAddr == PRIV_OFF);
    isWr    = reqValid && reqWrite;
    isRd    = reqValid && !reqWrite;

    strobes         = '0;
    strobes.acc     = reqValid;
    strobes.useMask = !reqPriv;
    strobes.wrSec   = isWr && hitSec && reqSecure;
    strobes.wrPriv  = isWr && hitPriv && reqSecure && reqPriv;
    strobes.rdSec   = isRd && hitSec;
    strobes.rdPriv  = isRd && hitPriv;
    strobes.err     = reqValid && !(strobes.wrSec || strobes.wrPriv ||
                                    strobes.rdSec || strobes.rdPriv);
  end

endmodule

// File: rtl/psab_regs.sv
module psab_regs
  import psab_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'hFD00_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic [DATA_W-1:0] secQ,
  output logic [DATA_W-1:0] privQ
);

  logic [DATA_W-1:0] secWe;
  logic [DATA_W-1:0] privWe;
  logic [DATA_W-1:0] rdMux;

  // Per-bit write enables; reserved positions get no enable at all.
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      assign secWe[i]  = strobes.wrSec && !(strobes.useMask && privQ[i]);
      assign privWe[i] = strobes.wrPriv;
    end else begin : g_rsvd
      assign secWe[i]  = 1'b0;
      assign privWe[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ  <= '0;
      privQ <= '0;
    end else begin
      secQ  <= (secQ & ~secWe) | (reqWdata & secWe);
      privQ <= (privQ & ~privWe) | (reqWdata & privWe);
    end
  end

  always_comb begin
    rdMux = '0;
    if (strobes.rdSec)  rdMux = secQ;
    if (strobes.rdPriv) rdMux = privQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strobes.acc;
      rspErr   <= strobes.err;
      rspRdata <= rdMux;
    end
  end

endmodule

// File: rtl/periph_sec_attr_bank.sv
module periph_sec_attr_bank
  import psab_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] SEC_OFF  = 12'h018,
  parameter logic [ADDR_W-1:0] PRIV_OFF = 12'h028,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'hFD00_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqStrb,
  input  logic                reqSecure,
  input  logic                reqPriv,
  output logic                rspValid,
  output logic                rspErr,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [DATA_W-1:0]   secModeVec,
  output logic [DATA_W-1:0]   privAttrVec
);

  ctrlStrobes_t strobes;

  psab_ctrl #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SEC_OFF (SEC_OFF),
    .PRIV_OFF(PRIV_OFF)
  ) ctrl_i (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqStrb  (reqStrb),
    .reqSecure(reqSecure),
    .reqPriv  (reqPriv),
    .strobes  (strobes)
  );

  psab_regs #(
    .DATA_W   (DATA_W),
    .IMPL_MASK(IMPL_MASK)
  ) regs_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqWdata(reqWdata),
    .rspValid(rspValid),
    .rspErr  (rspErr),
    .rspRdata(rspRdata),
    .secQ    (secModeVec),
    .privQ   (privAttrVec)
  );

endmodule

// File: rtl/psab_checker.sv
module psab_checker #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] IMPL_MASK = 32'hFD00_0000
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqWrite,
  input logic                reqSecure,
  input logic                reqPriv,
  input logic                rspValid,
  input logic                rspErr,
  input logic [DATA_W-1:0]   rspRdata,
  input logic [DATA_W-1:0]   secModeVec,
  input logic [DATA_W-1:0]   privAttrVec
);

  // R4: non-secure writers change nothing and are told so
  a_r4_nonsecure_write_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqSecure) |=>
      ($stable(secModeVec) && $stable(privAttrVec) && rspErr));

  // R3 and R8: a non-privileged writer never flips a protected bit
  a_r3_protected_bits_hold: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !reqPriv) |=>
      (((secModeVec ^ $past(secModeVec)) & $past(privAttrVec)) == '0) &&
      $stable(privAttrVec));

  // R5: reserved positions stay zero in both registers
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((secModeVec & ~IMPL_MASK) == '0) && ((privAttrVec & ~IMPL_MASK) == '0));

  // R10: a response follows each request one cycle later, and no other response
  a_r10_resp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  a_r10_no_spurious_resp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R7 and R9: rejected accesses return zero data
  a_r9_err_data_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> (rspRdata == '0));

  // R11: without a write the attribute vectors hold
  a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqWrite) |=> ($stable(secModeVec) && $stable(privAttrVec)));

endmodule

bind periph_sec_attr_bank psab_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .IMPL_MASK(IMPL_MASK)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqWrite   (reqWrite),
  .reqSecure  (reqSecure),
  .reqPriv    (reqPriv),
  .rspValid   (rspValid),
  .rspErr     (rspErr),
  .rspRdata   (rspRdata),
  .secModeVec (secModeVec),
  .privAttrVec(privAttrVec)
);

// File: tb/periph_sec_attr_bank_tb.sv
module periph_sec_attr_bank_tb_top;

  localparam logic [11:0] OFF_SEC  = 12'h018;
  localparam logic [11:0] OFF_PRIV = 12'h028;
  localparam logic [31:0] IMPL     = 32'hFD00_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqStrb = '0;
  logic        reqSecure = 1'b0;
  logic        reqPriv = 1'b0;
  logic        rspValid;
  logic        rspErr;
  logic [31:0] rspRdata;
  logic [31:0] secModeVec;
  logic [31:0] privAttrVec;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] mSec  = '0;
  logic [31:0] mPriv = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  periph_sec_attr_bank dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqStrb(reqStrb),
    .reqSecure(reqSecure), .reqPriv(reqPriv), .rspValid(rspValid),
    .rspErr(rspErr), .rspRdata(rspRdata), .secModeVec(secModeVec),
    .privAttrVec(privAttrVec)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
    end
  endtask

  function automatic string classify(input logic wr, input logic [11:0] a,
                                     input logic [3:0] s, input logic sec,
                                     input logic prv);
    if (s != 4'hF || a[1:0] != 2'b00) return "R7";
    if (a != OFF_SEC && a != OFF_PRIV) return "R9";
    if (!wr) return "R6";
    if (!sec) return "R4";
    if (a == OFF_PRIV) return prv ? "R2" : "R8";
    return prv ? "R2" : "R3";
  endfunction

  // One access: drive at a falling edge, sample the response at the next one.
  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [3:0] s, input logic sec, input logic prv);
    logic        word, mapped, expErr;
    logic [31:0] expData;
    string       tag;
    tag     = classify(wr, a, s, sec, prv);
    word    = (s == 4'hF) && (a[1:0] == 2'b00);
    mapped  = word && (a == OFF_SEC || a == OFF_PRIV);
    expData = '0;
    expErr  = 1'b0;
    if (!mapped) expErr = 1'b1;
    else if (!wr) expData = (a == OFF_SEC) ? mSec : mPriv;
    else if (!sec) expErr = 1'b1;
    else if (a == OFF_PRIV) begin
      if (prv) mPriv = d & IMPL;
      else expErr = 1'b1;
    end else begin
      logic [31:0] m;
      m = prv ? IMPL : (IMPL & ~mPriv);
      mSec = (mSec & ~m) | (d & m);
    end
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    reqStrb = s; reqSecure = sec; reqPriv = prv;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10", "rspValid", {31'b0, rspValid}, 32'd1);
    chk(tag, "rspErr", {31'b0, rspErr}, {31'b0, expErr});
    chk(tag, "rspRdata", rspRdata, expData);
    chk("R11", "secModeVec", secModeVec, mSec);
    chk("R11", "privAttrVec", privAttrVec, mPriv);
    chk("R5", "reserved", (secModeVec | privAttrVec) & ~IMPL, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "secModeVec", secModeVec, 32'h0);
    chk("R1", "privAttrVec", privAttrVec, 32'h0);
    chk("R1", "rspValid", {31'b0, rspValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    access(1'b0, OFF_SEC, 32'h0, 4'hF, 1'b0, 1'b0);          // R6 read by non-secure
    access(1'b1, OFF_SEC, 32'hFFFF_FFFF, 4'hF, 1'b0, 1'b1);  // R4
    access(1'b1, OFF_SEC, 32'hFFFF_FFFF, 4'hF, 1'b1, 1'b0);  // R2/R3: all unlocked, R5 reserved
    chk("R5", "secModeVec", secModeVec, 32'hFD00_0000);
    access(1'b1, OFF_PRIV, 32'hFFFF_FFFF, 4'hF, 1'b1, 1'b0); // R8 rejected
    access(1'b1, OFF_PRIV, 32'h8400_0000, 4'hF, 1'b1, 1'b1); // lock bits 31 and 26
    access(1'b1, OFF_SEC, 32'h0, 4'hF, 1'b1, 1'b0);          // R3: locked bits stay
    chk("R3", "locked hold", secModeVec, 32'h8400_0000);
    access(1'b1, OFF_SEC, 32'h0, 4'hF, 1'b1, 1'b1);          // R2 privileged clears all
    chk("R2", "priv clear", secModeVec, 32'h0);
    access(1'b1, OFF_SEC, 32'hFFFF_FFFF, 4'h7, 1'b1, 1'b1);  // R7 partial strobes
    access(1'b1, 12'h01A, 32'hFFFF_FFFF, 4'hF, 1'b1, 1'b1);  // R7 misaligned
    access(1'b0, 12'h01C, 32'h0, 4'hF, 1'b1, 1'b1);          // R9 unmapped read
    access(1'b1, 12'h100, 32'hFFFF_FFFF, 4'hF, 1'b1, 1'b1);  // R9 unmapped write
    access(1'b0, OFF_PRIV, 32'h0, 4'hF, 1'b0, 1'b0);         // R6
    // R10: idle cycle carries no response
    @(negedge clk);
    chk("R10", "idle rspValid", {31'b0, rspValid}, 32'h0);
    for (int n = 0; n < 600; n++) begin
      logic [11:0] a;
      logic [3:0]  s;
      int sel;
      sel = int'($urandom % 8);
      if (sel < 3)       a = OFF_SEC;
      else if (sel < 6)  a = OFF_PRIV;
      else if (sel == 6) a = 12'($urandom);
      else               a = OFF_SEC | 12'($urandom % 4);
      s = ($urandom % 5 == 0) ? 4'($urandom) : 4'hF;
      access(1'($urandom), a, $urandom, s, 1'($urandom), 1'($urandom));
      if ($urandom % 8 == 0) begin
        @(negedge clk);
        chk("R10", "idle rspValid", {31'b0, rspValid}, 32'h0);
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule